// File: doc/BRIEF.md
# Multi-port LUT-based distributed RAM

This block is a small random-access memory built the way lookup-table fabric builds it. Each storage cell holds 64 bits. A cell is arranged either as 64 words of 1 bit or as 32 words of 2 bits. Cells are placed side by side to make the word as wide as needed, and stacked in rows to make the memory as deep as needed, up to 256 words. When rows are stacked, the address bits above the cell address pick which row takes a write and which row feeds each read output.

A parameter picks how many ports the memory has and what each port can do:

- single: port A reads and writes.
- dual: A reads and writes, and B only reads.
- simple dual: A only writes, and B only reads.
- quad: A reads and writes, and B, C and D only read.

Each port has its own address. The clock, write enable and write data belong to port A only. Writes take effect on the rising clock edge. Reads are combinational from the port's address. An optional output register turns every active read port into a one-cycle synchronous read. The contents start at a parameter value and are never reset.

Top module: `lutram_mp`

## Requirements
- R1: When `wr_en` is high at a rising edge of `clk`, `wr_data` is stored at `addr_a`. When `wr_en` is low, no location changes, whatever `wr_data` holds.
- R2: With `OUT_REG`=0, every active read output shows the word at that port's current address combinationally, in the same cycle the address changes.
- R3: With `OUT_REG`=0, a read-only port whose address equals the address just written shows the new data right after that clock edge.
- R4: In single, dual and quad modes, `rd_data_a` shows the word at `addr_a`. It does not show the most recently written location.
- R5: Port activity follows `MODE`: PM_SINGLE=0 (A only), PM_DUAL=1 (A and B), PM_SIMPLE_DUAL=2 (B reads, A write-only), PM_QUAD=3 (A, B, C, D). Every inactive read output is held at 0.
- R6: With `CELL_W`=1 a cell is 64 words deep; with `CELL_W`=2 it is 32 words deep. DEPTH/cell-depth rows are stacked. The address bits above the cell address select the row for both write and read, so the full DEPTH (up to 256) is independently addressable.
- R7: With `OUT_REG`=1, each active read output shows, one cycle late, the word that its port's address selected at the previous rising edge. That word is taken before any write at that same edge.
- R8: `rst_n` low at a rising edge clears the read output registers to 0 (synchronous, active low). The stored contents are not affected by reset.
- R9: Before any write, every word reads as `INIT_WORD`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Write clock and output register clock |
| rst_n | input | 1 | Synchronous active-low clear of the read output registers |
| wr_en | input | 1 | Write enable for port A |
| addr_a | input | AW | Port A address (write address, and read address when A reads) |
| wr_data | input | WIDTH | Write data |
| rd_data_a | output | WIDTH | Port A read data |
| addr_b | input | AW | Port B read address |
| rd_data_b | output | WIDTH | Port B read data |
| addr_c | input | AW | Port C read address |
| rd_data_c | output | WIDTH | Port C read data |
| addr_d | input | AW | Port D read address |
| rd_data_d | output | WIDTH | Port D read data |

## Verification
The bench aims read-only addresses at the location being written. A design that registered the read path, or that fed read ports from a stale copy, would show the old word after the edge.

It writes on both sides of every row boundary (31/32, 63/64, 127/128, 255). A wrong row decode would alias rows or write two rows at once.

It holds `wr_en` low with new data present, and it pulses reset in the middle of the run. A design that ignores the enable would overwrite the word, and one that resets the storage would lose its contents.

Four instances cover all four modes, both cell shapes and both read latencies. An unused port that leaks data, or a registered output that samples after the write, would be caught.

// File: rtl/lutram_pkg.sv
// Shared definitions for the LUT-based distributed RAM.
// Assumes: storage cells of fixed 64-bit capacity, at most four ports.
package lutram_pkg;
    typedef enum logic [1:0] {
        PM_SINGLE      = 2'd0,
        PM_DUAL        = 2'd1,
        PM_SIMPLE_DUAL = 2'd2,
        PM_QUAD        = 2'd3
    } port_mode_e;

    localparam int CELL_BITS = 64;
    localparam int NPORT     = 4;
endpackage

// File: rtl/lutram_cell.sv
// One 64-bit storage cell: synchronous write, NPORT combinational reads.
// Assumes: CELL_W divides 64 evenly; contents are never reset.
module lutram_cell
    import lutram_pkg::*;
#(
    parameter int              CELL_W    = 1,
    parameter logic [CELL_W-1:0] INIT_BITS = '0,
    localparam int             CELL_D    = CELL_BITS / CELL_W,
    localparam int             CAW       = $clog2(CELL_D)
) (
    input  logic                         clk,
    input  logic                         we,
    input  logic [CAW-1:0]               waddr,
    input  logic [CELL_W-1:0]            wdata,
    input  logic [NPORT-1:0][CAW-1:0]    raddr,
    output logic [NPORT-1:0][CELL_W-1:0] rdata
);
    logic [CELL_W-1:0] mem [CELL_D] = '{default: INIT_BITS};

    // Store the write word on the clock edge when enabled.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    // One combinational read path per port.
    for (genvar p = 0; p < NPORT; p++) begin : g_rd
        assign rdata[p] = mem[raddr[p]];
    end
endmodule

// File: rtl/lutram_wdec.sv
// Row write-enable decoder: turns the upper address bits into one-hot row enables.
// Assumes: NROW <= 2**RSW.
module lutram_wdec #(
    parameter int NROW = 4,
    parameter int RSW  = 2
) (
    input  logic            we,
    input  logic [RSW-1:0]  row,
    output logic [NROW-1:0] row_we
);
    // Enable only the row addressed by the upper bits.
    always_comb begin
        for (int i = 0; i < NROW; i++) begin
            row_we[i] = we && (row == RSW'(i));
        end
    end
endmodule

// File: rtl/lutram_oreg.sv
// Optional read output register giving a synchronous read.
// Assumes: synchronous active-low clear.
module lutram_oreg #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    // Capture the combinational read word; clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    // R8
    oreg_clear_chk: assert property (@(posedge clk) !rst_n |=> q == '0);
endmodule

// File: rtl/lutram_mp.sv
// Multi-port distributed RAM built from 64-bit cells, stacked in rows and columns.
// Port A is the write port; MODE selects which ports can read.
// Assumes: WIDTH is a multiple of CELL_W; DEPTH is a power-of-two multiple of cell depth.
module lutram_mp
    import lutram_pkg::*;
#(
    parameter port_mode_e       MODE      = PM_QUAD,
    parameter int               DEPTH     = 128,
    parameter int               WIDTH     = 4,
    parameter int               CELL_W    = 2,
    parameter bit               OUT_REG   = 1'b1,
    parameter logic [WIDTH-1:0] INIT_WORD = '0,
    localparam int              AW        = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [AW-1:0]    addr_a,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] rd_data_a,
    input  logic [AW-1:0]    addr_b,
    output logic [WIDTH-1:0] rd_data_b,
    input  logic [AW-1:0]    addr_c,
    output logic [WIDTH-1:0] rd_data_c,
    input  logic [AW-1:0]    addr_d,
    output logic [WIDTH-1:0] rd_data_d
);
    localparam int CELL_D = CELL_BITS / CELL_W;
    localparam int CAW    = $clog2(CELL_D);
    localparam int NROW   = DEPTH / CELL_D;
    localparam int NCOL   = WIDTH / CELL_W;
    localparam int RSW    = (NROW > 1) ? $clog2(NROW) : 1;
    localparam logic [NPORT-1:0] RD_ON = {
        MODE == PM_QUAD,
        MODE == PM_QUAD,
        MODE != PM_SINGLE,
        MODE != PM_SIMPLE_DUAL
    };

    logic [NPORT-1:0][AW-1:0]             paddr;
    logic [NPORT-1:0][CAW-1:0]            caddr;
    logic [NPORT-1:0][RSW-1:0]            prow;
    logic [NROW-1:0]                      row_we;
    logic [NPORT-1:0][NROW-1:0][WIDTH-1:0] row_dat;
    logic [NPORT-1:0][WIDTH-1:0]          raw;
    logic [NPORT-1:0][WIDTH-1:0]          pout;

    assign paddr = {addr_d, addr_c, addr_b, addr_a};

    // Split each port address into cell address and row select.
    for (genvar p = 0; p < NPORT; p++) begin : g_split
        assign caddr[p] = paddr[p][CAW-1:0];
        if (NROW > 1) begin : g_rows
            assign prow[p] = paddr[p][AW-1:CAW];
        end else begin : g_one
            assign prow[p] = '0;
        end
    end

    lutram_wdec #(.NROW(NROW), .RSW(RSW)) u_wdec (
        .we     (wr_en),
        .row    (prow[0]),
        .row_we (row_we)
    );

    // Storage array: NROW rows by NCOL columns of cells.
    for (genvar r = 0; r < NROW; r++) begin : g_row
        for (genvar c = 0; c < NCOL; c++) begin : g_col
            logic [NPORT-1:0][CELL_W-1:0] crd;
            lutram_cell #(
                .CELL_W    (CELL_W),
                .INIT_BITS (INIT_WORD[c*CELL_W +: CELL_W])
            ) u_cell (
                .clk   (clk),
                .we    (row_we[r]),
                .waddr (caddr[0]),
                .wdata (wr_data[c*CELL_W +: CELL_W]),
                .raddr (caddr),
                .rdata (crd)
            );
            for (genvar p = 0; p < NPORT; p++) begin : g_fan
                assign row_dat[p][r][c*CELL_W +: CELL_W] = crd[p];
            end
        end
    end

    // Per-port row multiplexer, then mode gating and optional register.
    for (genvar p = 0; p < NPORT; p++) begin : g_port
        if (NROW > 1) begin : g_mux
            assign raw[p] = row_dat[p][prow[p]];
        end else begin : g_nomux
            assign raw[p] = row_dat[p][0];
        end

        if (!RD_ON[p]) begin : g_off
            assign pout[p] = '0;
        end else if (OUT_REG) begin : g_sync
            lutram_oreg #(.W(WIDTH)) u_oreg (
                .clk   (clk),
                .rst_n (rst_n),
                .d     (raw[p]),
                .q     (pout[p])
            );
            // R7
            sync_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) && $past(wr_en, 2) && ($past(paddr[p]) == $past(addr_a, 2))
                |-> pout[p] == $past(wr_data, 2));
        end else begin : g_async
            assign pout[p] = raw[p];
            if (p > 0) begin : g_ro
                // R3
                ro_newdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    $past(wr_en) && (paddr[p] == $past(addr_a))
                    |-> pout[p] == $past(wr_data));
            end else begin : g_rw
                // R4
                rw_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
                    $past(wr_en) && $stable(addr_a)
                    |-> pout[p] == $past(wr_data));
            end
        end
    end

    assign rd_data_a = pout[0];
    assign rd_data_b = pout[1];
    assign rd_data_c = pout[2];
    assign rd_data_d = pout[3];
endmodule

// File: tb/sim_lutram_mp.sv
// Bench: four configurations driven from shared stimulus, checked against bench models.
module sim_lutram_mp;
    import lutram_pkg::*;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic we = 1'b0;
    logic [7:0] wa = '0, ab = '0, ac = '0, ad = '0;
    logic [3:0] wd = '0;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    string phase = "start";

    always #4 clk = ~clk;

    logic [3:0] o0a, o0b, o0c, o0d;
    logic [1:0] o1a, o1b, o1c, o1d;
    logic [2:0] o2a, o2b, o2c, o2d;
    logic [1:0] o3a, o3b, o3c, o3d;

    logic [3:0] m0 [128];
    logic [1:0] m1 [256];
    logic [2:0] m2 [64];
    logic [1:0] m3 [32];
    logic [1:0] e1b = '0;

    lutram_mp #(.MODE(PM_QUAD), .DEPTH(128), .WIDTH(4), .CELL_W(2), .OUT_REG(1'b0),
                .INIT_WORD(4'hA)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(we), .addr_a(wa[6:0]), .wr_data(wd),
        .rd_data_a(o0a), .addr_b(ab[6:0]), .rd_data_b(o0b),
        .addr_c(ac[6:0]), .rd_data_c(o0c), .addr_d(ad[6:0]), .rd_data_d(o0d));

    lutram_mp #(.MODE(PM_SIMPLE_DUAL), .DEPTH(256), .WIDTH(2), .CELL_W(1), .OUT_REG(1'b1),
                .INIT_WORD(2'b01)) u1 (
        .clk(clk), .rst_n(rst_n), .wr_en(we), .addr_a(wa), .wr_data(wd[1:0]),
        .rd_data_a(o1a), .addr_b(ab), .rd_data_b(o1b),
        .addr_c(ac), .rd_data_c(o1c), .addr_d(ad), .rd_data_d(o1d));

    lutram_mp #(.MODE(PM_DUAL), .DEPTH(64), .WIDTH(3), .CELL_W(1), .OUT_REG(1'b0),
                .INIT_WORD(3'b101)) u2 (
        .clk(clk), .rst_n(rst_n), .wr_en(we), .addr_a(wa[5:0]), .wr_data(wd[2:0]),
        .rd_data_a(o2a), .addr_b(ab[5:0]), .rd_data_b(o2b),
        .addr_c(ac[5:0]), .rd_data_c(o2c), .addr_d(ad[5:0]), .rd_data_d(o2d));

    lutram_mp #(.MODE(PM_SINGLE), .DEPTH(32), .WIDTH(2), .CELL_W(2), .OUT_REG(1'b0),
                .INIT_WORD(2'b10)) u3 (
        .clk(clk), .rst_n(rst_n), .wr_en(we), .addr_a(wa[4:0]), .wr_data(wd[1:0]),
        .rd_data_a(o3a), .addr_b(ab[4:0]), .rd_data_b(o3b),
        .addr_c(ac[4:0]), .rd_data_c(o3c), .addr_d(ad[4:0]), .rd_data_d(o3d));

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s (%s) t=%0t: got %0d expected %0d", req, phase, $time, act, exp);
        end
    endtask

    // Compare every output against the models; post=1 means just after an edge.
    task automatic check_all(input bit post);
        string ro;
        ro = post ? "R3" : "R2";
        chk("R4", o0a, m0[wa[6:0]]);
        chk(ro,   o0b, m0[ab[6:0]]);
        chk(ro,   o0c, m0[ac[6:0]]);
        chk(ro,   o0d, m0[ad[6:0]]);
        chk("R5", o1a, 0);
        chk("R7", o1b, e1b);
        chk("R5", o1c, 0);
        chk("R5", o1d, 0);
        chk("R4", o2a, m2[wa[5:0]]);
        chk(ro,   o2b, m2[ab[5:0]]);
        chk("R5", o2c, 0);
        chk("R5", o2d, 0);
        chk("R4", o3a, m3[wa[4:0]]);
        chk("R5", o3b, 0);
        chk("R5", o3c, 0);
        chk("R5", o3d, 0);
    endtask

    // One clock cycle: drive at negedge, check, model the edge, check again.
    task automatic cyc(input logic e, input logic [7:0] a, input logic [3:0] d,
                       input logic [7:0] b, input logic [7:0] c, input logic [7:0] dd);
        @(negedge clk);
        we = e; wa = a; wd = d; ab = b; ac = c; ad = dd;
        #1 check_all(1'b0);
        @(posedge clk);
        e1b = rst_n ? m1[ab] : 2'b00;
        if (we) begin
            m0[wa[6:0]] = wd;
            m1[wa]      = wd[1:0];
            m2[wa[5:0]] = wd[2:0];
            m3[wa[4:0]] = wd[1:0];
        end
        #1 check_all(1'b1);
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        void'($urandom(32'h1A2B3C4D));
        for (int i = 0; i < 128; i++) m0[i] = 4'hA;
        for (int i = 0; i < 256; i++) m1[i] = 2'b01;
        for (int i = 0; i < 64; i++)  m2[i] = 3'b101;
        for (int i = 0; i < 32; i++)  m3[i] = 2'b10;

        phase = "R8 R9 reset";
        for (int i = 0; i < 3; i++) cyc(1'b0, 8'(i * 7), 4'h0, 8'(i), 8'(i + 40), 8'(i + 90));
        rst_n = 1'b1;

        phase = "R9 init";
        cyc(1'b0, 8'd0, 4'h5, 8'd63, 8'd64, 8'd127);
        cyc(1'b0, 8'd255, 4'h5, 8'd255, 8'd128, 8'd31);
        cyc(1'b0, 8'd17, 4'h5, 8'd200, 8'd1, 8'd100);

        phase = "R1 write then hold";
        cyc(1'b1, 8'd5, 4'h9, 8'd5, 8'd5, 8'd5);
        cyc(1'b0, 8'd5, 4'h3, 8'd5, 8'd5, 8'd5);
        cyc(1'b0, 8'd5, 4'h6, 8'd5, 8'd6, 8'd4);

        phase = "R6 row boundaries";
        cyc(1'b1, 8'd31,  4'h1, 8'd0, 8'd0, 8'd0);
        cyc(1'b1, 8'd32,  4'h2, 8'd31, 8'd0, 8'd0);
        cyc(1'b1, 8'd63,  4'h3, 8'd32, 8'd31, 8'd0);
        cyc(1'b1, 8'd64,  4'h4, 8'd63, 8'd32, 8'd31);
        cyc(1'b1, 8'd127, 4'h5, 8'd64, 8'd63, 8'd32);
        cyc(1'b1, 8'd128, 4'h6, 8'd127, 8'd64, 8'd63);
        cyc(1'b1, 8'd255, 4'h7, 8'd128, 8'd127, 8'd64);
        cyc(1'b0, 8'd0,   4'h0, 8'd255, 8'd128, 8'd127);
        cyc(1'b0, 8'd0,   4'h0, 8'd31, 8'd255, 8'd32);

        phase = "R3 same-address read";
        cyc(1'b1, 8'd77, 4'hC, 8'd77, 8'd77, 8'd77);
        cyc(1'b1, 8'd77, 4'h3, 8'd77, 8'd77, 8'd77);
        cyc(1'b1, 8'd200, 4'hE, 8'd200, 8'd72, 8'd200);

        phase = "R8 mid-run reset";
        rst_n = 1'b0;
        cyc(1'b0, 8'd77, 4'h0, 8'd77, 8'd200, 8'd5);
        rst_n = 1'b1;
        cyc(1'b0, 8'd200, 4'h0, 8'd77, 8'd200, 8'd5);
        cyc(1'b0, 8'd5, 4'h0, 8'd200, 8'd77, 8'd5);

        phase = "random";
        for (int i = 0; i < 3000; i++) begin
            r = 8'($urandom);
            cyc(($urandom % 3) != 0, r, 4'($urandom),
                (($urandom % 4) == 0) ? r : 8'($urandom),
                (($urandom % 4) == 0) ? r : 8'($urandom),
                8'($urandom));
        end

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule